// File: doc/BRIEF.md
# Received Pause Transmit Gate

This block sits beside a full-duplex Ethernet MAC transmitter and decides whether the transmitter may begin new frames while it honours flow-control requests from the link partner. The receive path has already parsed and validated each incoming pause frame. It hands over a one-cycle event that carries the 16-bit pause time in slot-time quanta. Each quantum is 512 bit times, and the MAC supplies a one-cycle tick for each one that elapses.

A pause event with a nonzero time arms a quanta timer and raises a transmit-off status flag. The transmit-permit output falls only once the transmitter reports that no frame is in flight, so a frame already on the wire is always completed. Transmission resumes when the timer runs out or when a pause event with a zero time (an XON) arrives; either one clears the flag at once. XON events are counted in a saturating counter that software may clear synchronously. A single enable input carries the outcome of flow-control negotiation. While it is low, pause requests are not honoured.

Top module: `pause_tx_gate`

## Requirements
- R1: After reset (rst_n low, synchronous) tx_off is 0, tx_permit is 1 and xon_count is 0.
- R2: A pause event (pause_valid high) with pause_time nonzero while fc_en is high sets tx_off on the next clock edge; if tx_busy is low at that edge, tx_permit also falls on that edge.
- R3: While tx_permit is high and tx_busy is high at a clock edge, tx_permit stays high after that edge; a pending stop lowers tx_permit at the first edge where tx_busy is low and tx_off is still set. tx_permit is never low while tx_off is low.
- R4: While paused, each quantum_tick lowers the remaining time by one; the edge on which it reaches zero clears tx_off and raises tx_permit, so a pause of N quanta ends after exactly N ticks.
- R5: A pause event with pause_time equal to zero while fc_en is high (an XON) clears tx_off and raises tx_permit on the next edge.
- R6: A nonzero pause event while already paused reloads the remaining time with the new value rather than adding to it; a load in the same cycle as a tick takes precedence over the tick.
- R7: While fc_en is low, pause events do not affect tx_off or tx_permit, and lowering fc_en while paused clears tx_off and raises tx_permit on the next edge.
- R8: Every pause event with pause_time zero increments xon_count by one on the next edge, whatever the value of fc_en.
- R9: xon_count holds at its all-ones value (CNT_W bits, default 32) instead of wrapping.
- R10: xon_clr high clears xon_count to zero on the next edge and takes precedence over an XON event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_en | input | 1 | Honour received pause requests (negotiated flow control) |
| pause_valid | input | 1 | One-cycle pulse: a validated pause frame was received |
| pause_time | input | QW (16) | Pause time in quanta carried by that frame |
| quantum_tick | input | 1 | One-cycle pulse per 512-bit-time quantum |
| tx_busy | input | 1 | High while the transmitter is sending a frame |
| xon_clr | input | 1 | Synchronous clear of the XON counter |
| tx_off | output | 1 | Status: transmission is paused |
| tx_permit | output | 1 | Transmitter may start a new frame |
| xon_count | output | CNT_W (32) | Saturating count of received XON frames |

## Verification
The gating is exercised with a short pause that runs out by ticks alone, a pause that arrives in the middle of a frame, an XON that cuts a pause short, and a second pause that lands while the first is still counting down. The frame-in-progress case tells a stop at the frame boundary apart from an immediate stop. The overlapping pause tells a reload apart from an accumulation, because the two predict different expiry ticks. Pause and XON events sent with the enable low separate the gated timing path from the counter, which must still count. Counter saturation and the priority of clear over increment are driven by a directed run.

// File: rtl/pause_gate_pkg.sv
// Package: shared types for the received-pause transmit gate.
// Assumes: nothing beyond IEEE 1800-2017.
package pause_gate_pkg;

    // Classification of one incoming pause event.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_XOFF = 2'd1,
        EV_XON  = 2'd2
    } pause_ev_t;

endpackage

// File: rtl/pause_event_decode.sv
// Module: pause_event_decode
// Classifies a validated pause event as a stop request or a resume request.
// Assumes: pause_valid is a single-cycle pulse from the receive parser.
module pause_event_decode
    import pause_gate_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          pause_valid,
    input  logic [QW-1:0] pause_time,
    output pause_ev_t     ev
);

    localparam logic [QW-1:0] ZERO_TIME = '0;

    // Map a valid frame to XON when its time is zero, else to XOFF.
    always_comb begin
        if (!pause_valid)
            ev = EV_NONE;
        else if (pause_time == ZERO_TIME)
            ev = EV_XON;
        else
            ev = EV_XOFF;
    end

endmodule

// File: rtl/pause_quanta_timer.sv
// Module: pause_quanta_timer
// Holds the remaining pause time and counts it down once per quantum tick.
// Assumes: load has priority over tick; clear has priority over both.
module pause_quanta_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          tick,
    output logic          expire,
    output logic          running
);

    localparam logic [QW-1:0] ONE  = QW'(1);
    localparam logic [QW-1:0] NONE = '0;

    logic [QW-1:0] remain_q;

    // Flag the tick that takes the remaining time from one to zero.
    always_comb begin
        expire = tick && !load && !clear && (remain_q == ONE);
    end

    // Load, count down or clear the remaining time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= NONE;
        else if (clear)
            remain_q <= NONE;
        else if (load)
            remain_q <= load_val;
        else if (tick && remain_q != NONE)
            remain_q <= remain_q - ONE;
    end

    assign running = (remain_q != NONE);

endmodule

// File: rtl/tx_halt_ctrl.sv
// Module: tx_halt_ctrl
// Keeps the transmit-off status and lowers the permit only at a frame boundary.
// Assumes: tx_busy is high for every cycle of a frame in flight.
module tx_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_off,
    input  logic resume,
    input  logic tx_busy,
    output logic tx_off,
    output logic tx_permit
);

    logic off_q;
    logic halt_q;
    logic off_d;
    logic halt_d;

    // Next status: a new stop wins over a resume in the same cycle.
    always_comb begin
        if (set_off)
            off_d = 1'b1;
        else if (resume)
            off_d = 1'b0;
        else
            off_d = off_q;
    end

    // Next halt: follow the status, but only start halting between frames.
    always_comb begin
        halt_d = off_d && (halt_q || !tx_busy);
    end

    // Register status and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            off_q  <= off_d;
            halt_q <= halt_d;
        end
    end

    assign tx_off    = off_q;
    assign tx_permit = !halt_q;

endmodule

// File: rtl/xon_event_counter.sv
// Module: xon_event_counter
// Saturating event counter with a synchronous clear.
// Assumes: clear has priority over an increment in the same cycle.
module xon_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count events, hold at all-ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_ONE;
    end

    assign count = cnt_q;

endmodule

// File: rtl/pause_tx_gate.sv
// Module: pause_tx_gate (top)
// Gates MAC transmission on received pause requests: stop at frame boundary,
// resume on timer expiry or XON, and count XON frames.
// Assumes: pause events are already validated; fc_en reflects negotiation.
module pause_tx_gate
    import pause_gate_pkg::*;
#(
    parameter int QW    = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en,
    input  logic             pause_valid,
    input  logic [QW-1:0]    pause_time,
    input  logic             quantum_tick,
    input  logic             tx_busy,
    input  logic             xon_clr,
    output logic             tx_off,
    output logic             tx_permit,
    output logic [CNT_W-1:0] xon_count
);

    pause_ev_t ev;
    logic      xoff_hon;
    logic      xon_hon;
    logic      tmr_expire;
    logic      tmr_running;
    logic      resume_any;

    pause_event_decode #(.QW(QW)) u_dec (
        .pause_valid (pause_valid),
        .pause_time  (pause_time),
        .ev          (ev)
    );

    // Honour stop and resume only when flow control is enabled.
    always_comb begin
        xoff_hon   = fc_en && (ev == EV_XOFF);
        xon_hon    = fc_en && (ev == EV_XON);
        resume_any = xon_hon || tmr_expire || !fc_en;
    end

    pause_quanta_timer #(.QW(QW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (xon_hon || !fc_en),
        .load     (xoff_hon),
        .load_val (pause_time),
        .tick     (quantum_tick),
        .expire   (tmr_expire),
        .running  (tmr_running)
    );

    tx_halt_ctrl u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_off   (xoff_hon),
        .resume    (resume_any),
        .tx_busy   (tx_busy),
        .tx_off    (tx_off),
        .tx_permit (tx_permit)
    );

    xon_event_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (xon_clr),
        .inc   (ev == EV_XON),
        .count (xon_count)
    );

endmodule

// File: rtl/pause_tx_gate_chk.sv
// Module: pause_tx_gate_chk
// Checker bound to pause_tx_gate; relates its ports over time.
module pause_tx_gate_chk #(
    parameter int QW    = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fc_en,
    input logic             pause_valid,
    input logic [QW-1:0]    pause_time,
    input logic             tx_busy,
    input logic             xon_clr,
    input logic             tx_off,
    input logic             tx_permit,
    input logic [CNT_W-1:0] xon_count,
    input logic             tmr_running
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_STOP_SETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fc_en && pause_valid && pause_time != '0 |=> tx_off); // R2
    AST_BUSY_KEEPS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit && tx_busy |=> tx_permit); // R3
    AST_PERMIT_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_permit |-> tx_off); // R3
    AST_RUN_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_running |-> tx_off); // R4
    AST_XON_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        fc_en && pause_valid && pause_time == '0 |=> !tx_off && tx_permit); // R5
    AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !tx_off && tx_permit); // R7
    AST_XON_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid && pause_time == '0 && !xon_clr && xon_count != CNT_MAX
        |=> xon_count == $past(xon_count) + 1'b1); // R8
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        xon_count == CNT_MAX && !xon_clr |=> xon_count == CNT_MAX); // R9
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        xon_clr |=> xon_count == '0); // R10

endmodule

bind pause_tx_gate pause_tx_gate_chk #(.QW(QW), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fc_en       (fc_en),
    .pause_valid (pause_valid),
    .pause_time  (pause_time),
    .tx_busy     (tx_busy),
    .xon_clr     (xon_clr),
    .tx_off      (tx_off),
    .tx_permit   (tx_permit),
    .xon_count   (xon_count),
    .tmr_running (tmr_running)
);

// File: tb/sim_pause_tx_gate.sv
module sim_pause_tx_gate;

    localparam int CLK_PERIOD = 10;
    localparam int QW         = 16;
    localparam int CW         = 4;
    localparam int NV         = 21;

    typedef struct packed {
        logic          en;
        logic          pv;
        logic [15:0]   q;
        logic          busy;
        logic          tick;
        logic          clr;
        logic          off;
        logic          perm;
        logic [3:0]    cnt;
        logic [3:0]    req;
    } vec_t;

    // en pv q busy tick clr | off perm cnt | req
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,16'd3,1'b0,1'b0,1'b0, 1'b1,1'b0,4'd0, 4'd2},  // R2 stop when idle
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd0, 4'd4},  // R4 tick 1 of 3
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd0, 4'd4},  // R4 tick 2 of 3
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b0,1'b1,4'd0, 4'd4},  // R4 expiry
        '{1'b1,1'b1,16'd5,1'b1,1'b0,1'b0, 1'b1,1'b1,4'd0, 4'd3},  // R3 stop mid-frame
        '{1'b1,1'b0,16'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,4'd0, 4'd3},  // R3 frame continues
        '{1'b1,1'b0,16'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,4'd0, 4'd3},  // R3 boundary stop
        '{1'b1,1'b1,16'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,4'd1, 4'd5},  // R5 XON resume
        '{1'b1,1'b1,16'd2,1'b0,1'b0,1'b0, 1'b1,1'b0,4'd1, 4'd2},  // R2 stop 2
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd1, 4'd4},  // R4 1 left
        '{1'b1,1'b1,16'd4,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd1, 4'd6},  // R6 reload beats tick
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd1, 4'd6},  // R6 3 left
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd1, 4'd6},  // R6 2 left
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,4'd1, 4'd6},  // R6 1 left
        '{1'b1,1'b0,16'd0,1'b0,1'b1,1'b0, 1'b0,1'b1,4'd1, 4'd6},  // R6 expiry after 4
        '{1'b0,1'b1,16'd7,1'b0,1'b0,1'b0, 1'b0,1'b1,4'd1, 4'd7},  // R7 ignored when off
        '{1'b1,1'b1,16'd9,1'b0,1'b0,1'b0, 1'b1,1'b0,4'd1, 4'd2},  // R2 stop again
        '{1'b0,1'b0,16'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,4'd1, 4'd7},  // R7 disable clears
        '{1'b0,1'b1,16'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,4'd2, 4'd8},  // R8 counts when off
        '{1'b1,1'b1,16'd0,1'b0,1'b0,1'b1, 1'b0,1'b1,4'd0, 4'd10}, // R10 clear wins
        '{1'b1,1'b1,16'd0,1'b0,1'b1,1'b0, 1'b0,1'b1,4'd1, 4'd8}   // R8 count again
    };

    logic          clk;
    logic          rst_n;
    logic          fc_en;
    logic          pause_valid;
    logic [QW-1:0] pause_time;
    logic          quantum_tick;
    logic          tx_busy;
    logic          xon_clr;
    logic          tx_off;
    logic          tx_permit;
    logic [CW-1:0] xon_count;

    int checks;
    int errors;
    bit done;

    pause_tx_gate #(.QW(QW), .CNT_W(CW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .fc_en        (fc_en),
        .pause_valid  (pause_valid),
        .pause_time   (pause_time),
        .quantum_tick (quantum_tick),
        .tx_busy      (tx_busy),
        .xon_clr      (xon_clr),
        .tx_off       (tx_off),
        .tx_permit    (tx_permit),
        .xon_count    (xon_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic eo, input logic ep,
                         input logic [CW-1:0] ec);
        checks++;
        if (tx_off !== eo || tx_permit !== ep || xon_count !== ec) begin
            errors++;
            $display("FAIL %s: off/permit/count got %b/%b/%0d expected %b/%b/%0d",
                     req, tx_off, tx_permit, xon_count, eo, ep, ec);
        end
    endtask

    task automatic drive(input logic en, input logic pv, input logic [QW-1:0] q,
                         input logic busy, input logic tick, input logic clr);
        fc_en = en; pause_valid = pv; pause_time = q;
        tx_busy = busy; quantum_tick = tick; xon_clr = clr;
        @(negedge clk);
    endtask

    initial begin
        checks = 0; errors = 0; done = 1'b0;
        rst_n = 1'b0;
        fc_en = 1'b1; pause_valid = 1'b0; pause_time = '0;
        quantum_tick = 1'b0; tx_busy = 1'b0; xon_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b1, '0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        check("R1", 1'b0, 1'b1, '0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].en, VECS[i].pv, VECS[i].q, VECS[i].busy,
                  VECS[i].tick, VECS[i].clr);
            check($sformatf("R%0d vec %0d", VECS[i].req, i),
                  VECS[i].off, VECS[i].perm, VECS[i].cnt);
        end

        // R9: drive many XON events; counter holds at all-ones
        for (int k = 0; k < 20; k++)
            drive(1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0);
        check("R9", 1'b0, 1'b1, '1);
        drive(1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0);
        check("R9", 1'b0, 1'b1, '1);
        // R10: plain clear
        drive(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        check("R10", 1'b0, 1'b1, '0);

        // R1: reset while paused returns to idle
        drive(1'b1, 1'b1, 16'd50, 1'b0, 1'b0, 1'b0);
        check("R2", 1'b1, 1'b0, '0);
        rst_n = 1'b0;
        drive(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        check("R1", 1'b0, 1'b1, '0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        check("R1", 1'b0, 1'b1, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule